// File: doc/BRIEF.md
# Serial Control Word Loader

This block receives configuration words for a frequency synthesizer over a three-wire synchronous port made of a serial clock, a serial data line and a load strobe. All three arrive from another clock domain and are resynchronised into the local clock. Each rising edge of the serial clock shifts one data bit into a single 19-bit shift register. The most significant bit of a word goes first, so the last bit of every word is its routing bit.

When the load strobe rises, the word in the shift register is copied into one of two holding banks. The routing bit decides which bank. If it is 1, the reference bank takes the word: the 14-bit reference divide value and three mode bits (prescaler select, phase polarity, monitor select). If it is 0, the divider bank takes the word: the 7-bit swallow value and the 11-bit main counter value. The reference word is 18 bits long and the divider word is 19 bits long. Both words end at the same register position, so a single decoder serves both.

A small controller sequences the load with three named states. `ST_IDLE` accepts shift edges. The transition idle→xfer is taken on the first cycle the synchronised strobe is high. `ST_XFER` issues a one-cycle write into the selected bank. It then goes xfer→hold if the strobe is still high, or xfer→idle if the strobe is already low. `ST_HOLD` waits, and the transition hold→idle is taken when the strobe falls. Shift edges are discarded whenever the strobe is high.

Top module: `cfgword_loader`

## Requirements
- R1: A rising edge on `ser_clk` while `ser_le` is low shifts `ser_data` into register position 1, and earlier bits move one place toward the top. Words are sent most significant bit first.
- R2: When `ser_le` rises and position 1 holds 1, the reference bank loads:
  - `ref_ratio` from positions 2..15 (position 2 is its LSB);
  - `pre_sel` from position 16;
  - `phase_pol` from position 17;
  - `mon_sel` from position 18.
  The divider bank is left unchanged.
- R3: When `ser_le` rises and position 1 holds 0, the divider bank loads `swal_cnt` from positions 2..8 (LSB at position 2) and `main_cnt` from positions 9..19 (LSB at position 9). The reference bank is left unchanged.
- R4: Both banks keep their contents across any number of serial clock edges that occur without a load strobe.
- R5: After reset every bank output is 0.
- R6: A serial clock edge that arrives while `ser_le` is high does not enter the shift register, so a repeated strobe loads the same word again.
- R7: Only the most recent bits count. Bits shifted in before the final 19 (divider word) or before the final 18 (reference word) do not affect the loaded fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data bit |
| ser_le | input | 1 | Load strobe, active high |
| ref_ratio | output | 14 | Reference divide value |
| pre_sel | output | 1 | Prescaler modulus select |
| phase_pol | output | 1 | Phase comparator polarity |
| mon_sel | output | 1 | Lock/monitor output select |
| swal_cnt | output | 7 | Swallow counter preset |
| main_cnt | output | 11 | Main counter preset |

## Verification
The shift register cannot be seen at the ports, so the hardest case is showing that a serial edge arriving during the load strobe was discarded (R6). The stimulus for this case runs in four steps:
1. Load a divider word.
2. While the strobe is still high, clock in a 1.
3. Lower the strobe.
4. Pulse the strobe again.

If the stray bit had been accepted, routing bit 1 would redirect the second load into the reference bank and corrupt it. The check is that the reference bank is unchanged and the divider bank still holds the original word. R7 is reached by prefixing words with junk bits, and R2 by a leading stray bit above the 18-bit reference word.

// File: rtl/scl_pkg.sv
package scl_pkg;
    parameter int REF_W  = 14;
    parameter int SWAL_W = 7;
    parameter int MAIN_W = 11;
    localparam int FRAME_W = 1 + SWAL_W + MAIN_W;
    localparam int REF_LEN = 1 + REF_W + 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_HOLD = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic [REF_W-1:0] ratio;
        logic             pre_sel;
        logic             pol;
        logic             mon_sel;
    } ref_cfg_t;

    typedef struct packed {
        logic [SWAL_W-1:0] swal;
        logic [MAIN_W-1:0] main;
    } div_cfg_t;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d_in;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q_out = stg[STAGES-1];
endmodule

// File: rtl/scl_shreg.sv
module scl_shreg
    import scl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sh_en,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] sr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (sh_en) begin
            sr_q <= {sr_q[FRAME_W-2:0], bit_in};
        end
    end

    // R1: the newest bit lands at position 1
    assert_new_bit_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sh_en |=> sr_q[0] == $past(bit_in));
    // R1: older bits move up by one
    assert_bits_move_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sh_en |=> sr_q[FRAME_W-1:1] == $past(sr_q[FRAME_W-2:0]));
endmodule

// File: rtl/scl_ctrl.sv
module scl_ctrl
    import scl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic le_s,
    input  logic sclk_rise,
    input  logic route_bit,
    output logic sh_en,
    output logic ref_we,
    output logic div_we
);
    ld_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (le_s)  state_d = ST_XFER;
            ST_XFER: state_d = le_s ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (!le_s) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        sh_en  = 1'b0;
        ref_we = 1'b0;
        div_we = 1'b0;
        unique case (state_q)
            ST_IDLE: sh_en = sclk_rise & ~le_s;
            ST_XFER: begin
                ref_we = route_bit;
                div_we = ~route_bit;
            end
            ST_HOLD: ;
            default: ;
        endcase
    end

    // R6: no shifting while the strobe is high
    assert_no_shift_in_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        le_s |-> !sh_en);
    // R2/R3: one write per strobe, never two banks at once
    assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_we || div_we) |=> !(ref_we || div_we));
    assert_xfer_after_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_we || div_we) |-> $past(le_s));
endmodule

// File: rtl/scl_banks.sv
module scl_banks
    import scl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_we,
    input  logic               div_we,
    input  logic [FRAME_W-1:0] sr_q,
    output ref_cfg_t           ref_cfg,
    output div_cfg_t           div_cfg
);
    ref_cfg_t ref_n;
    div_cfg_t div_n;

    always_comb begin
        ref_n.ratio   = sr_q[REF_W:1];
        ref_n.pre_sel = sr_q[REF_W+1];
        ref_n.pol     = sr_q[REF_W+2];
        ref_n.mon_sel = sr_q[REF_W+3];
        div_n.swal    = sr_q[SWAL_W:1];
        div_n.main    = sr_q[FRAME_W-1:SWAL_W+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cfg <= '0;
            div_cfg <= '0;
        end else begin
            if (ref_we) ref_cfg <= ref_n;
            if (div_we) div_cfg <= div_n;
        end
    end

    // R4: banks hold without a write
    assert_ref_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_we |=> $stable(ref_cfg));
    assert_div_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !div_we |=> $stable(div_cfg));
    // R2: reference fields come from positions 2..18
    assert_ref_ratio_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_we |=> ref_cfg.ratio == $past(sr_q[REF_W:1]));
    // R3: main value from positions 9..19
    assert_main_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
        div_we |=> div_cfg.main == $past(sr_q[FRAME_W-1:SWAL_W+1]));
endmodule

// File: rtl/cfgword_loader.sv
module cfgword_loader
    import scl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic [REF_W-1:0]  ref_ratio,
    output logic              pre_sel,
    output logic              phase_pol,
    output logic              mon_sel,
    output logic [SWAL_W-1:0] swal_cnt,
    output logic [MAIN_W-1:0] main_cnt
);
    logic [2:0]         sync_q;
    logic               sclk_s, dat_s, le_s, sclk_d;
    logic               sclk_rise, sh_en, ref_we, div_we;
    logic [FRAME_W-1:0] sr_q;
    ref_cfg_t           ref_cfg;
    div_cfg_t           div_cfg;

    scl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({ser_le, ser_data, ser_clk}),
        .q_out (sync_q)
    );
    assign {le_s, dat_s, sclk_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end
    assign sclk_rise = sclk_s & ~sclk_d;

    scl_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .le_s      (le_s),
        .sclk_rise (sclk_rise),
        .route_bit (sr_q[0]),
        .sh_en     (sh_en),
        .ref_we    (ref_we),
        .div_we    (div_we)
    );

    scl_shreg u_shreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .sh_en  (sh_en),
        .bit_in (dat_s),
        .sr_q   (sr_q)
    );

    scl_banks u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_we  (ref_we),
        .div_we  (div_we),
        .sr_q    (sr_q),
        .ref_cfg (ref_cfg),
        .div_cfg (div_cfg)
    );

    assign ref_ratio = ref_cfg.ratio;
    assign pre_sel   = ref_cfg.pre_sel;
    assign phase_pol = ref_cfg.pol;
    assign mon_sel   = ref_cfg.mon_sel;
    assign swal_cnt  = div_cfg.swal;
    assign main_cnt  = div_cfg.main;

    // R6: register frozen across a cycle where the strobe was high
    assert_sr_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        le_s |=> $stable(sr_q));
endmodule

// File: tb/tb_cfgword_loader.sv
module tb_cfgword_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [13:0] ref_ratio;
    logic pre_sel, phase_pol, mon_sel;
    logic [6:0]  swal_cnt;
    logic [10:0] main_cnt;
    int n_chk = 0, n_bad = 0;
    logic [13:0] e_ratio = '0;
    logic e_sw = 0, e_fc = 0, e_lds = 0;
    logic [6:0]  e_a = '0;
    logic [10:0] e_n = '0;

    always #2.5 clk = ~clk;

    cfgword_loader dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        ser_data = b; wclk(3);
        ser_clk = 1'b1; wclk(3);
        ser_clk = 1'b0; wclk(3);
    endtask

    task automatic send(input logic [31:0] w, input int len);
        for (int i = len - 1; i >= 0; i--) sbit(w[i]);
    endtask

    task automatic pulse_le;
        ser_le = 1'b1; wclk(6);
        ser_le = 1'b0; wclk(6);
    endtask

    task automatic check_all(input string req);
        chk({req, " ratio"}, 32'(ref_ratio), 32'(e_ratio));
        chk({req, " sw"},    32'(pre_sel),   32'(e_sw));
        chk({req, " fc"},    32'(phase_pol), 32'(e_fc));
        chk({req, " lds"},   32'(mon_sel),   32'(e_lds));
        chk({req, " swal"},  32'(swal_cnt),  32'(e_a));
        chk({req, " main"},  32'(main_cnt),  32'(e_n));
    endtask

    function automatic logic [31:0] ref_word(logic [13:0] r, logic sw, logic fc, logic lds);
        return 32'({lds, fc, sw, r, 1'b1});
    endfunction

    function automatic logic [31:0] div_word(logic [6:0] a, logic [10:0] n);
        return 32'({n, a, 1'b0});
    endfunction

    task automatic t_reset;
        check_all("R5");
    endtask

    task automatic t_ref_load;
        e_ratio = 14'h1A5B; e_sw = 1; e_fc = 0; e_lds = 1;
        send(ref_word(e_ratio, e_sw, e_fc, e_lds), 18);
        pulse_le;
        check_all("R2 R1");
    endtask

    task automatic t_div_load;
        e_a = 7'h55; e_n = 11'h4C3;
        send(div_word(e_a, e_n), 19);
        pulse_le;
        check_all("R3");
    endtask

    task automatic t_hold;
        send(32'hDEAD_BEEF, 30);
        check_all("R4");
    endtask

    task automatic t_prefix;
        send(32'h2D, 6);
        sbit(1'b1);
        e_ratio = 14'h0005; e_sw = 0; e_fc = 1; e_lds = 0;
        send(ref_word(e_ratio, e_sw, e_fc, e_lds), 18);
        pulse_le;
        check_all("R7 ref");
        send(32'h3F, 6);
        e_a = 7'h7F; e_n = 11'h005;
        send(div_word(e_a, e_n), 19);
        pulse_le;
        check_all("R7 div");
    endtask

    task automatic t_block;
        e_a = 7'h0A; e_n = 11'h7FF;
        send(div_word(e_a, e_n), 19);
        ser_le = 1'b1; wclk(6);
        sbit(1'b1);
        ser_le = 1'b0; wclk(6);
        check_all("R6 first");
        pulse_le;
        check_all("R6 again");
    endtask

    task automatic t_second_ref;
        e_ratio = 14'h3FFF; e_sw = 0; e_fc = 1; e_lds = 1;
        send(ref_word(e_ratio, e_sw, e_fc, e_lds), 18);
        pulse_le;
        check_all("R2 second");
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wclk(4);
        rst_n = 1'b1;
        wclk(4);
        t_reset();
        t_ref_load();
        t_div_load();
        t_hold();
        t_prefix();
        t_block();
        t_second_ref();
        finish_run();
    end
endmodule